// File: doc/BRIEF.md
# Scan Chain Non-Transition Counter

This block keeps a running tally of the non-transitions held in a group of scan chains while test data is shifted through them. A non-transition is a pair of neighbouring bits in a chain that carry the same value, either 00 or 11. A clock controller can read the tally to choose a faster shift clock when the chains are quiet and a slower one when they are busy.

On every cycle with shift enable high, each chain reports two comparisons. The first is between the bit about to enter the chain and the bit in its first flip-flop, which marks a non-transition arriving. The second is between the last two flip-flops, which marks a non-transition leaving. A parallel counter adds the number of arriving pairs across all chains and subtracts the number of leaving pairs in one registered update. A vector-start pulse clears the tally before each new vector is scanned in. A build parameter removes the leaving-side logic for use where peak activity is assumed and only arrivals matter.

Shift enable and vector start are plain control strobes. The block accepts a shift on every cycle and never applies back-pressure, so it needs no ready signal.

Top module: `scan_act_mon`

## Requirements
- R1: For chain i, an arrival is counted when `scan_in[i]` equals `head_q[i]`. Both 00 and 11 count.
- R2: When FULL_PEAK is 0, a departure for chain i is counted when `tail_prev[i]` equals `tail_last[i]`.
- R3: On a cycle with `shift_en` high and `vec_start` low, `nt_count` changes in the following cycle by the number of arrivals minus the number of departures, summed over all chains.
- R4: On a cycle with `shift_en` low and `vec_start` low, `nt_count` keeps its value, whatever the chain inputs are.
- R5: `vec_start` high sets `nt_count` to zero on the next cycle. It takes priority over a shift in the same cycle.
- R6: When the net change would take the count below zero, `nt_count` stays at zero.
- R7: When the net change would take the count above 2^CW-1, `nt_count` holds at that value. CW is clog2(NCH*CHAIN_LEN+1), which is 6 bits with the default parameters, so the ceiling is 63.
- R8: With FULL_PEAK set to 1, the `tail_prev` and `tail_last` inputs have no effect, and the count never drops during a shift.
- R9: While `rst_n` is low, `nt_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_start | input | 1 | Clears the tally at the start of a vector |
| shift_en | input | 1 | High on scan shift cycles |
| scan_in | input | NCH | Bit entering each chain |
| head_q | input | NCH | Contents of the first flip-flop of each chain |
| tail_prev | input | NCH | Contents of the second-to-last flip-flop of each chain |
| tail_last | input | NCH | Contents of the last flip-flop of each chain |
| nt_count | output | clog2(NCH*CHAIN_LEN+1) | Running non-transition count |

## Verification
The hardest cases to reach are the two clamps, especially a cycle where departures outnumber arrivals while the count is already low. In a real chain that cannot happen, because a pair can only leave after it has entered. The bench therefore drives the head and tail sides independently rather than modelling a chain. This lets it force a cycle with two arrivals and four departures from a zero count. It also holds four arrivals per cycle for seventeen cycles to reach and stay at the ceiling. A second instance built without the departure logic receives the same stimulus, so the difference between the two instances shows directly at the ports.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_STEP  = 2'd2
  } scm_op_e;

  function automatic int cnt_width(input int total_bits);
    return $clog2(total_bits + 1);
  endfunction
endpackage

// File: rtl/scm_pair_detect.sv
module scm_pair_detect #(
  parameter int NCH       = 4,
  parameter bit FULL_PEAK = 1'b0
) (
  input  logic [NCH-1:0] scan_in,
  input  logic [NCH-1:0] head_q,
  input  logic [NCH-1:0] tail_prev,
  input  logic [NCH-1:0] tail_last,
  output logic [NCH-1:0] arrive,
  output logic [NCH-1:0] depart
);
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign arrive[i] = ~(scan_in[i] ^ head_q[i]);
    if (FULL_PEAK) begin : g_up_only
      logic unused_tail;
      assign unused_tail = tail_prev[i] ^ tail_last[i];
      assign depart[i]   = 1'b0;
    end else begin : g_updown
      assign depart[i] = ~(tail_prev[i] ^ tail_last[i]);
    end
  end
endmodule

// File: rtl/scm_popcount.sv
module scm_popcount #(
  parameter int NCH = 4,
  localparam int PW = $clog2(NCH + 1)
) (
  input  logic [NCH-1:0] bits,
  output logic [PW-1:0]  ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < NCH; i++) begin
      ones = ones + PW'(bits[i]);
    end
  end
endmodule

// File: rtl/scm_sat_counter.sv
module scm_sat_counter
  import scm_pkg::*;
#(
  parameter int CW = 6,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  scm_op_e       op,
  input  logic [PW-1:0] ups,
  input  logic [PW-1:0] downs,
  output logic [CW-1:0] count
);
  localparam int MAXV = (1 << CW) - 1;

  logic [CW-1:0] next_cnt;

  always_comb begin
    int sum_v;
    sum_v    = int'(count) + int'(ups) - int'(downs);
    next_cnt = count;
    unique case (op)
      OP_CLEAR: next_cnt = '0;
      OP_STEP: begin
        if (sum_v < 0)         next_cnt = '0;
        else if (sum_v > MAXV) next_cnt = CW'(MAXV);
        else                   next_cnt = CW'(sum_v);
      end
      default: next_cnt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_cnt;
  end
endmodule

// File: rtl/scan_act_mon.sv
module scan_act_mon
  import scm_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CHAIN_LEN = 8,
  parameter bit FULL_PEAK = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 vec_start,
  input  logic                                 shift_en,
  input  logic [NCH-1:0]                       scan_in,
  input  logic [NCH-1:0]                       head_q,
  input  logic [NCH-1:0]                       tail_prev,
  input  logic [NCH-1:0]                       tail_last,
  output logic [$clog2(NCH*CHAIN_LEN+1)-1:0]   nt_count
);
  localparam int CW = cnt_width(NCH * CHAIN_LEN);
  localparam int PW = $clog2(NCH + 1);

  logic [NCH-1:0] arrive, depart;
  logic [PW-1:0]  n_up, n_down;
  scm_op_e        op;

  scm_pair_detect #(.NCH(NCH), .FULL_PEAK(FULL_PEAK)) u_det (
    .scan_in(scan_in), .head_q(head_q),
    .tail_prev(tail_prev), .tail_last(tail_last),
    .arrive(arrive), .depart(depart)
  );

  scm_popcount #(.NCH(NCH)) u_pc_up   (.bits(arrive), .ones(n_up));
  scm_popcount #(.NCH(NCH)) u_pc_down (.bits(depart), .ones(n_down));

  always_comb begin
    if (vec_start)     op = OP_CLEAR;
    else if (shift_en) op = OP_STEP;
    else               op = OP_HOLD;
  end

  scm_sat_counter #(.CW(CW), .PW(PW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .op(op),
    .ups(n_up), .downs(n_down), .count(nt_count)
  );
endmodule

// File: rtl/scan_act_mon_chk.sv
module scan_act_mon_chk #(
  parameter int NCH       = 4,
  parameter int CHAIN_LEN = 8,
  parameter bit FULL_PEAK = 1'b0
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               vec_start,
  input logic                               shift_en,
  input logic [NCH-1:0]                     scan_in,
  input logic [NCH-1:0]                     head_q,
  input logic [NCH-1:0]                     tail_prev,
  input logic [NCH-1:0]                     tail_last,
  input logic [$clog2(NCH*CHAIN_LEN+1)-1:0] nt_count
);
  logic step;
  assign step = shift_en && !vec_start;

  AST_CLEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_start |=> nt_count == '0); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !vec_start) |=> $stable(nt_count)); // R4

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (int'(nt_count) <= int'($past(nt_count)) + NCH) &&
             (int'(nt_count) + NCH >= int'($past(nt_count)))); // R3

  AST_NO_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ((scan_in ^ head_q) == {NCH{1'b1}})) |=>
      nt_count <= $past(nt_count)); // R1

  AST_NO_DEPART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ((tail_prev ^ tail_last) == {NCH{1'b1}})) |=>
      nt_count >= $past(nt_count)); // R2

  if (FULL_PEAK) begin : g_fp
    AST_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> nt_count >= $past(nt_count)); // R8
  end
endmodule

bind scan_act_mon scan_act_mon_chk #(
  .NCH(NCH), .CHAIN_LEN(CHAIN_LEN), .FULL_PEAK(FULL_PEAK)
) u_chk (.*);

// File: tb/sim_scan_act_mon.sv
`timescale 1ns/1ps
module sim_scan_act_mon;
  localparam int NCH = 4;
  localparam int LEN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vec_start = 1'b0;
  logic       shift_en = 1'b0;
  logic [3:0] scan_in = '0, head_q = '0, tail_prev = '0, tail_last = '0;
  logic [5:0] cnt0, cnt1;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scan_act_mon #(.NCH(NCH), .CHAIN_LEN(LEN), .FULL_PEAK(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .vec_start(vec_start), .shift_en(shift_en),
    .scan_in(scan_in), .head_q(head_q), .tail_prev(tail_prev),
    .tail_last(tail_last), .nt_count(cnt0));

  scan_act_mon #(.NCH(NCH), .CHAIN_LEN(LEN), .FULL_PEAK(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .vec_start(vec_start), .shift_en(shift_en),
    .scan_in(scan_in), .head_q(head_q), .tail_prev(tail_prev),
    .tail_last(tail_last), .nt_count(cnt1));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic vs, input logic sh, input logic [3:0] si,
                     input logic [3:0] hd, input logic [3:0] tp,
                     input logic [3:0] tl);
    vec_start = vs; shift_en = sh; scan_in = si;
    head_q = hd; tail_prev = tp; tail_last = tl;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1; check("R9 reset u0", cnt0, 0);
    check("R9 reset u1", cnt1, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_arrive();
    cyc(0, 1, 4'b0101, 4'b0100, 4'b1010, 4'b0101);
    check("R1 three arrivals", cnt0, 3);
    cyc(0, 1, 4'b1111, 4'b1111, 4'b1010, 4'b0101);
    check("R1 ones pairs", cnt0, 7);
    cyc(0, 1, 4'b0000, 4'b0000, 4'b1010, 4'b0101);
    check("R1 zeros pairs", cnt0, 11);
  endtask

  task automatic t_depart();
    cyc(0, 1, 4'b0000, 4'b1111, 4'b0110, 4'b0011);
    check("R2 two departures", cnt0, 9);
  endtask

  task automatic t_net();
    cyc(0, 1, 4'b1100, 4'b1101, 4'b1000, 4'b0110);
    check("R3 net plus two", cnt0, 11);
  endtask

  task automatic t_hold();
    cyc(0, 0, 4'b1111, 4'b1111, 4'b0000, 4'b0000);
    check("R4 hold u0", cnt0, 11);
    cyc(0, 0, 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    check("R4 hold again", cnt0, 11);
  endtask

  task automatic t_clear();
    cyc(1, 1, 4'b1111, 4'b1111, 4'b1010, 4'b0101);
    check("R5 clear over shift u0", cnt0, 0);
    check("R5 clear over shift u1", cnt1, 0);
  endtask

  task automatic t_floor();
    cyc(0, 1, 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    check("R6 floor at zero", cnt0, 0);
  endtask

  task automatic t_fullpeak();
    cyc(1, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    cyc(0, 1, 4'b0011, 4'b0000, 4'b0000, 4'b0000);
    check("R6 two up four down", cnt0, 0);
    check("R8 departures ignored", cnt1, 2);
    cyc(0, 1, 4'b1010, 4'b1010, 4'b1111, 4'b1111);
    check("R3 four up four down", cnt0, 0);
    check("R8 up only", cnt1, 6);
  endtask

  task automatic t_ceiling();
    cyc(1, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    for (int k = 0; k < 15; k++) cyc(0, 1, 4'b1111, 4'b1111, 4'b0101, 4'b1010);
    check("R7 below ceiling", cnt0, 60);
    cyc(0, 1, 4'b1111, 4'b1111, 4'b0101, 4'b1010);
    check("R7 clamp at max", cnt0, 63);
    cyc(0, 1, 4'b1111, 4'b1111, 4'b0101, 4'b1010);
    check("R7 stays at max", cnt0, 63);
    check("R7 u1 at max", cnt1, 63);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_arrive();
    t_depart();
    t_net();
    t_hold();
    t_clear();
    t_floor();
    t_fullpeak();
    t_ceiling();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule